// File: doc/BRIEF.md
# Repeating Register Window Decoder

This block sits on the slave address path of a bus wrapper in front of a PCIe controller core. For every incoming request address it decides whether the access lands on the core's controller-configuration register block, on its address-translation register block, or on the memory/BAR space behind them. The decode is done on the address taken modulo a programmable window size. Both register blocks therefore reappear as copies in every window, at each integer multiple of that size.

The window size and the two register-block base offsets are 64-bit values. Software writes each one as two 32-bit words through a small write port. The value takes effect when its high word is written. If the window size is set to all-ones, the repetition stops: each register block then answers only at its absolute base, and BAR/MMIO addresses above the first window are no longer shadowed.

The result is registered. One cycle after a valid request, the block presents a target select and an address. For a register-block hit, that address is the offset inside the 4 KiB block. For the memory side, it is the untouched request address.

Top module: `alias_win_dec`

## Requirements
- R1: After reset, the window size is 0x1000000, the configuration-block base is 0x0 and the translation-block base is 0x1000.
- R2: An address whose value modulo the window size falls in a register block's range is steered to that block, at every multiple of the window size.
- R3: With the window size all-ones, no repetition occurs. The in-window offset equals the full address.
- R4: Each register block spans exactly 4096 bytes from its base. Base+0xFFF hits the block and base+0x1000 does not.
- R5: When an offset falls in both ranges, the configuration block (select 2'b01) wins over the translation block.
- R6: Select codes are 2'b00 for memory, 2'b01 for the configuration block and 2'b10 for the translation block. Memory responses carry the request address unchanged. Register responses carry the offset minus the block base, which is always below 4096.
- R7: Configuration word indices are 0/1 for the window size (low/high), 2/3 for the configuration-block base and 4/5 for the translation-block base. A low-word write only stages data and does not change decoding. A high-word write commits the high word together with the last staged low word.
- R8: A window-size commit whose 64-bit value is zero or is neither a power of two nor all-ones is discarded, and the previous size stays in force.
- R9: The response valid follows the request valid after exactly one clock. While the response valid is low, the select is 2'b00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cfg_we_i | input | 1 | Configuration word write strobe |
| cfg_idx_i | input | 3 | Configuration word index (0..5) |
| cfg_wdata_i | input | 32 | Configuration write data |
| req_valid_i | input | 1 | Request address valid |
| req_addr_i | input | 64 | Request address |
| rsp_valid_o | output | 1 | Decode result valid |
| rsp_sel_o | output | 2 | Target select: 00 memory, 01 configuration block, 10 translation block |
| rsp_addr_o | output | 64 | Block offset for register targets, original address for memory |

## Verification
A corrupted committed window size or base shows up on the very next decoded request: addresses in later windows land on the wrong target, or register offsets come out shifted. A staging or commit fault shows up one request after the faulty write. It appears as a premature change after a low-word write, or as a mixed value after the high-word write. A rejection fault shows up as lost or wrong aliasing right after an illegal size write. Because the output register adds only one cycle, every such fault is visible in the first response that follows the bad state.

// File: rtl/alias_win_pkg.sv
package alias_win_pkg;
  localparam int unsigned ADDR_W   = 64;
  localparam int unsigned CFG_W    = 32;
  localparam int unsigned NUM_CFG  = 3;
  localparam int unsigned BLK_W    = 12;

  localparam logic [ADDR_W-1:0] SIZE_RST = 64'h0000_0000_0100_0000;
  localparam logic [ADDR_W-1:0] CBLK_RST = 64'h0;
  localparam logic [ADDR_W-1:0] TBLK_RST = 64'h0000_0000_0000_1000;

  typedef enum logic [1:0] {
    SEL_MEM  = 2'b00,
    SEL_CBLK = 2'b01,
    SEL_TBLK = 2'b10
  } sel_e;
endpackage

// File: rtl/alias_cfg_word.sv
module alias_cfg_word #(
  parameter int unsigned        HALF_W      = 32,
  parameter logic [2*HALF_W-1:0] RST_VAL    = '0,
  parameter bit                 CHECK_SIZE  = 1'b0
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                lo_we_i,
  input  logic                hi_we_i,
  input  logic [HALF_W-1:0]   wdata_i,
  output logic [2*HALF_W-1:0] val_o
);
  localparam int unsigned W = 2*HALF_W;

  logic [HALF_W-1:0] stage_lo_q;
  logic [W-1:0]      val_q;
  logic [W-1:0]      cand;
  logic              cand_ok;

  assign cand = {wdata_i, stage_lo_q};

  generate
    if (CHECK_SIZE) begin : g_chk
      always_comb begin
        cand_ok = (cand == '1) ||
                  ((cand != '0) && ((cand & (cand - W'(1))) == '0));
      end
    end else begin : g_nochk
      assign cand_ok = 1'b1;
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stage_lo_q <= RST_VAL[HALF_W-1:0];
      val_q      <= RST_VAL;
    end else begin
      if (lo_we_i) stage_lo_q <= wdata_i;
      if (hi_we_i && cand_ok) val_q <= cand;
    end
  end

  assign val_o = val_q;

  a_r7_low_no_commit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lo_we_i && !hi_we_i) |=> $stable(val_q));

  generate
    if (CHECK_SIZE) begin : g_asrt
      a_r8_size_legal: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (val_q == '1) || ((val_q != '0) && ((val_q & (val_q - W'(1))) == '0)));
    end
  endgenerate
endmodule

// File: rtl/alias_win_decode.sv
module alias_win_decode
  import alias_win_pkg::*;
#(
  parameter int unsigned AW    = 64,
  parameter int unsigned BLK_B = 12
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [AW-1:0] size_i,
  input  logic [AW-1:0] cbase_i,
  input  logic [AW-1:0] tbase_i,
  input  logic          req_valid_i,
  input  logic [AW-1:0] req_addr_i,
  output logic          rsp_valid_o,
  output logic [1:0]    rsp_sel_o,
  output logic [AW-1:0] rsp_addr_o
);
  localparam logic [AW-1:0] BLK_LEN = AW'(1) << BLK_B;

  logic [AW-1:0] mask, off, d_c, d_t;
  logic          hit_c, hit_t;
  logic [1:0]    sel_d;
  logic [AW-1:0] addr_d;

  always_comb begin
    mask  = (size_i == '1) ? '1 : (size_i - AW'(1));
    off   = req_addr_i & mask;
    d_c   = off - cbase_i;
    d_t   = off - tbase_i;
    hit_c = d_c < BLK_LEN;
    hit_t = d_t < BLK_LEN;
    if (!req_valid_i) begin
      sel_d  = SEL_MEM;
      addr_d = '0;
    end else if (hit_c) begin
      sel_d  = SEL_CBLK;
      addr_d = AW'(d_c[BLK_B-1:0]);
    end else if (hit_t) begin
      sel_d  = SEL_TBLK;
      addr_d = AW'(d_t[BLK_B-1:0]);
    end else begin
      sel_d  = SEL_MEM;
      addr_d = req_addr_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rsp_valid_o <= 1'b0;
      rsp_sel_o   <= SEL_MEM;
      rsp_addr_o  <= '0;
    end else begin
      rsp_valid_o <= req_valid_i;
      rsp_sel_o   <= sel_d;
      rsp_addr_o  <= addr_d;
    end
  end

  a_r9_valid_rise: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i |=> rsp_valid_o);
  a_r9_valid_fall: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_valid_i |=> !rsp_valid_o);
  a_r9_idle_sel: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rsp_valid_o |-> (rsp_sel_o == SEL_MEM));
  a_r6_sel_legal: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_sel_o != 2'b11);
  a_r6_reg_off_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsp_sel_o != SEL_MEM) |-> (rsp_addr_o < BLK_LEN));
  a_r6_mem_passthru: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && !hit_c && !hit_t) |=> (rsp_sel_o == SEL_MEM) && (rsp_addr_o == $past(req_addr_i)));
endmodule

// File: rtl/alias_win_dec.sv
module alias_win_dec
  import alias_win_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cfg_we_i,
  input  logic [2:0]        cfg_idx_i,
  input  logic [CFG_W-1:0]  cfg_wdata_i,
  input  logic              req_valid_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  output logic              rsp_valid_o,
  output logic [1:0]        rsp_sel_o,
  output logic [ADDR_W-1:0] rsp_addr_o
);
  localparam logic [ADDR_W-1:0] RST_TAB [NUM_CFG] = '{SIZE_RST, CBLK_RST, TBLK_RST};

  logic [ADDR_W-1:0] cfg_val [NUM_CFG];

  for (genvar g = 0; g < NUM_CFG; g++) begin : g_cfg
    logic lo_we, hi_we;
    assign lo_we = cfg_we_i && (cfg_idx_i == 3'(2*g));
    assign hi_we = cfg_we_i && (cfg_idx_i == 3'(2*g+1));
    alias_cfg_word #(
      .HALF_W    (CFG_W),
      .RST_VAL   (RST_TAB[g]),
      .CHECK_SIZE(g == 0)
    ) u_word (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .lo_we_i (lo_we),
      .hi_we_i (hi_we),
      .wdata_i (cfg_wdata_i),
      .val_o   (cfg_val[g])
    );
  end

  alias_win_decode #(
    .AW   (ADDR_W),
    .BLK_B(BLK_W)
  ) u_dec (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .size_i     (cfg_val[0]),
    .cbase_i    (cfg_val[1]),
    .tbase_i    (cfg_val[2]),
    .req_valid_i(req_valid_i),
    .req_addr_i (req_addr_i),
    .rsp_valid_o(rsp_valid_o),
    .rsp_sel_o  (rsp_sel_o),
    .rsp_addr_o (rsp_addr_o)
  );
endmodule

// File: tb/alias_win_dec_tb.sv
module alias_win_dec_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [2:0]  cfg_idx = '0;
  logic [31:0] cfg_wdata = '0;
  logic        req_valid = 1'b0;
  logic [63:0] req_addr = '0;
  logic        rsp_valid;
  logic [1:0]  rsp_sel;
  logic [63:0] rsp_addr;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  logic [63:0] m_val [3];
  logic [31:0] m_stage [3];

  always #4 clk = ~clk;

  alias_win_dec dut_i (
    .clk_i(clk), .rst_ni(rst_n), .cfg_we_i(cfg_we), .cfg_idx_i(cfg_idx),
    .cfg_wdata_i(cfg_wdata), .req_valid_i(req_valid), .req_addr_i(req_addr),
    .rsp_valid_o(rsp_valid), .rsp_sel_o(rsp_sel), .rsp_addr_o(rsp_addr)
  );

  function automatic bit size_ok(input logic [63:0] s);
    return (s == '1) || ((s != 0) && ((s & (s - 64'd1)) == 0));
  endfunction

  function automatic logic [65:0] model(input logic [63:0] a);
    logic [63:0] mask, off, dc, dt;
    mask = (m_val[0] == '1) ? '1 : m_val[0] - 64'd1;
    off  = a & mask;
    dc   = off - m_val[1];
    dt   = off - m_val[2];
    if (dc < 64'd4096) return {2'b01, dc};
    if (dt < 64'd4096) return {2'b10, dt};
    return {2'b00, a};
  endfunction

  task automatic chk(input string req, input logic [65:0] act, input logic [65:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual sel=%b addr=%h expected sel=%b addr=%h",
               req, act[65:64], act[63:0], exp[65:64], exp[63:0]);
    end
  endtask

  task automatic cfg_wr(input int idx, input logic [31:0] d);
    logic [63:0] v;
    @(negedge clk);
    cfg_we = 1'b1; cfg_idx = 3'(idx); cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
    if (idx % 2 == 0) m_stage[idx/2] = d;
    else begin
      v = {d, m_stage[idx/2]};
      if (idx != 1 || size_ok(v)) m_val[idx/2] = v;
    end
  endtask

  task automatic cfg_set(input int which, input logic [63:0] v);
    cfg_wr(2*which, v[31:0]);
    cfg_wr(2*which+1, v[63:32]);
  endtask

  task automatic probe(input string req, input logic [63:0] a);
    @(negedge clk);
    req_valid = 1'b1; req_addr = a;
    @(negedge clk);
    req_valid = 1'b0;
    checks++;
    if (rsp_valid !== 1'b1) begin
      errors++;
      $display("FAIL R9: actual valid=%b expected valid=1", rsp_valid);
    end
    chk(req, {rsp_sel, rsp_addr}, model(a));
  endtask

  initial begin
    #(8 * 150000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h1d2c_3b4a));
    m_val[0] = 64'h100_0000; m_val[1] = 64'h0; m_val[2] = 64'h1000;
    m_stage[0] = 32'h100_0000; m_stage[1] = 32'h0; m_stage[2] = 32'h1000;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R9 reset / idle state
    chk("R9 reset idle", {rsp_valid, 1'b0, rsp_sel, rsp_addr[62:0]}, 66'h0);
    // R1 defaults, R4 boundaries
    chk("R1 dflt cblk", model(64'h0), {2'b01, 64'h0});
    probe("R1 cblk at 0", 64'h0);
    probe("R1 tblk at 0x1000", 64'h1000);
    chk("R4 tblk last byte model", model(64'h1fff), {2'b10, 64'hfff});
    probe("R4 tblk last byte", 64'h1fff);
    probe("R4 just past tblk", 64'h2000);
    probe("R4 cblk last byte", 64'h0fff);
    // R2 aliasing at several multiples
    probe("R2 alias win1 cblk", 64'h100_0010);
    probe("R2 alias win3 tblk", 64'h300_1abc);
    probe("R2 alias high win", 64'hfedc_ba98_7600_0004);
    probe("R6 mem passthru", 64'h100_2000);
    // R9 idle gap
    @(negedge clk);
    checks++;
    if (rsp_valid !== 1'b0 || rsp_sel !== 2'b00) begin
      errors++;
      $display("FAIL R9: actual valid=%b sel=%b expected valid=0 sel=00", rsp_valid, rsp_sel);
    end
    // R7 low-word write alone must not change decode
    cfg_wr(0, 32'hffff_ffff);
    probe("R7 low only keeps alias", 64'h100_0010);
    chk("R7 model alias kept", model(64'h100_0010), {2'b01, 64'h10});
    // R3 all-ones commit
    cfg_wr(1, 32'hffff_ffff);
    chk("R3 model no alias", model(64'h100_0010), {2'b00, 64'h100_0010});
    probe("R3 no alias win1", 64'h100_0010);
    probe("R3 absolute tblk", 64'h1004);
    probe("R3 far address", 64'hffff_ffff_ff00_0000);
    // R8 illegal sizes rejected
    cfg_set(0, 64'h3000);
    probe("R8 non-pow2 rejected", 64'h100_0010);
    chk("R8 model unchanged", model(64'h100_0010), {2'b00, 64'h100_0010});
    cfg_set(0, 64'h0);
    probe("R8 zero rejected", 64'h200_1000);
    // R5 overlap priority
    cfg_set(0, 64'h1_0000);
    cfg_set(1, 64'h800);
    chk("R5 model overlap", model(64'h1_1000), {2'b01, 64'h800});
    probe("R5 cblk wins overlap", 64'h1_1000);
    probe("R5 tblk tail", 64'h1_1900);
    // R7 high-only write uses last staged low
    cfg_wr(5, 32'h0000_0001);
    probe("R7 hi commit with staged low", 64'h1_0000_1010);
    // random
    for (int n = 0; n < 400; n++) begin
      if (n % 40 == 0) begin
        cfg_set(0, (n % 200 == 0) ? 64'hffff_ffff_ffff_ffff : (64'd1 << (13 + $urandom_range(0, 30))));
        cfg_set(1, 64'({$urandom, $urandom}) & 64'h0000_00ff_ffff_fffc);
        cfg_set(2, 64'({$urandom, $urandom}) & 64'h0000_00ff_ffff_fffc);
      end
      begin
        logic [63:0] a;
        logic [63:0] k;
        k = {$urandom, $urandom};
        case ($urandom_range(0, 2))
          0: a = (k & ~(m_val[0] - 64'd1)) + m_val[1] + 64'($urandom_range(0, 4200));
          1: a = (k & ~(m_val[0] - 64'd1)) + m_val[2] + 64'($urandom_range(0, 4200));
          default: a = k;
        endcase
        probe("R2/R6 random", a);
      end
    end
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule